// File: doc/BRIEF.md
# Descriptor-Driven Configuration Item DMA Engine

This block lets a host move configuration data between system memory and a store of numbered configuration items without touching each byte through a register. The host builds a 16-byte descriptor in memory and writes its physical address into a 64-bit pointer register. The write to the less significant half is what starts the job. The engine then works through a fixed sequence. It reads the descriptor with four word reads. It decodes the control word and may switch to a new item. It performs at most one data operation on the current item: read out, write in, or skip ahead. Last, it writes the control word back to memory as a status code: zero for success, or only the error bit set.

The item store sits outside the block. The engine presents an item key and a byte offset, and the store answers with the byte at that position, the item's length and whether the item accepts writes. The engine keeps the key and the offset between jobs, so a series of descriptors without the select bit walks further along the same item. Data moves through the memory master one byte per beat.

Top module: `cfg_dma_engine`

## Requirements
- R1: After reset, and again after every job completes, both pointer halves read as zero. Register word index 2 reads as a status word whose bit 0 is 1 while a job is in progress.
- R2: Register word index 0 holds pointer bits 63:32 and word index 1 holds bits 31:0. On reg_wdata and reg_rdata, lane i (bits 8i+7:8i) carries the byte at register offset i. The pointer is big-endian, so the byte at the lowest offset is the most significant byte.
- R3: A write to word index 1 while idle starts a job. While a job is in progress, writes to word index 0 or 1 are ignored.
- R4: A job fetches the descriptor with four 32-bit reads, at P, P+4, P+8 and P+12, where P is the pointer. On mem_rdata and mem_wdata, lane i carries the byte at address+i. The descriptor holds a control word, then a byte length, then a 64-bit data address (P+8 holds the upper half). All three are big-endian.
- R5: When control bit 3 is set, item_key takes control bits 31:16 and item_offset becomes 0 before any data operation.
- R6: Control bit 1 has priority over bits 4 and 2. It copies length bytes of the item, starting at the current offset, to memory from the data address upward. Each byte is one write with a one-hot mem_be. Bytes at or beyond the item length are written as 0x00. The offset advances by length, and the job reports success.
- R7: Control bit 4 with bit 1 clear copies length bytes from memory into the item, and the offset advances by length. If offset+length exceeds the item length, or item_writable is low, nothing is written, the offset is unchanged, and the job reports an error.
- R8: Control bit 2, with bits 1 and 4 both clear, advances the offset by length and moves no data.
- R9: A job ends with a full-word write to P. The bytes are 00 00 00 00 on success and 00 00 00 01 on error. The pointer is then cleared and the status bit drops.
- R10: Once mem_req is raised, it stays high and mem_we, mem_addr, mem_be and mem_wdata stay stable until a cycle in which mem_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; reg_rdata is valid the next cycle |
| reg_addr | input | 2 | Register word index: 0 pointer high, 1 pointer low/trigger, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 64 | Memory byte address |
| mem_be | output | 4 | Memory byte-lane enables |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid when mem_ready is high |
| item_key | output | 16 | Selected item key |
| item_offset | output | 32 | Byte offset within the selected item |
| item_rdata | input | 8 | Item byte at item_key/item_offset |
| item_len | input | 32 | Length of the selected item in bytes |
| item_writable | input | 1 | Selected item accepts writes |
| item_wr | output | 1 | Write item_wdata at item_key/item_offset at this clock edge |
| item_wdata | output | 8 | Item write byte |

## Verification
A descriptor word latched in the wrong slot or in the wrong byte order sends data to the wrong place or picks the wrong operation. This is visible in memory as soon as the job's writeback lands, a few dozen cycles after the trigger. A cursor that drifts shows up in the next job that runs without a select, as a shifted byte sequence. A faulty bounds or permission test shows up as an item that changed when it should not have, together with a wrong status word. A stuck sequencer keeps the status bit high, and the polling bench catches that within its retry limit.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;

  localparam int WORD_W = 32;
  localparam int PTR_W  = 64;

  localparam int CTL_ERR   = 0;
  localparam int CTL_READ  = 1;
  localparam int CTL_SKIP  = 2;
  localparam int CTL_SEL   = 3;
  localparam int CTL_WRITE = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_CHECK, S_MOVE, S_WB
  } eng_state_t;

  typedef enum logic [1:0] {
    OP_NONE, OP_READ, OP_WRITE, OP_SKIP
  } eng_op_t;

  // byte reversal between little-lane bus words and big-endian values
  function automatic logic [WORD_W-1:0] swap32(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // read outranks write, write outranks skip
  function automatic eng_op_t pick_op(input logic [WORD_W-1:0] ctl);
    if (ctl[CTL_READ])       return OP_READ;
    else if (ctl[CTL_WRITE]) return OP_WRITE;
    else if (ctl[CTL_SKIP])  return OP_SKIP;
    else                     return OP_NONE;
  endfunction

endpackage

// File: rtl/cfgdma_ptr_reg.sv
module cfgdma_ptr_reg
  import cfgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              done,
  output logic [PTR_W-1:0]  ptr,
  output logic              start
);

  localparam int HALF = PTR_W / 2;

  logic busy_any;
  assign busy_any = busy | start;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      start     <= 1'b0;
      reg_rdata <= '0;
    end else begin
      start <= 1'b0;
      if (done) begin
        ptr <= '0;
      end else if (reg_wr && !busy_any) begin
        if (reg_addr == 2'd0) begin
          ptr[PTR_W-1:HALF] <= swap32(reg_wdata);
        end else if (reg_addr == 2'd1) begin
          ptr[HALF-1:0] <= swap32(reg_wdata);
          start         <= 1'b1;
        end
      end
      if (reg_rd) begin
        case (reg_addr)
          2'd0:    reg_rdata <= swap32(ptr[PTR_W-1:HALF]);
          2'd1:    reg_rdata <= swap32(ptr[HALF-1:0]);
          2'd2:    reg_rdata <= {{(WORD_W-1){1'b0}}, busy_any};
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfgdma_cursor.sv
module cfgdma_cursor #(
  parameter int KEY_W = 16,
  parameter int OFF_W = 32,
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_load,
  input  logic [KEY_W-1:0] sel_key,
  input  logic             step,
  input  logic             jump,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic [LEN_W-1:0] item_len,
  output logic [KEY_W-1:0] key,
  output logic [OFF_W-1:0] offset,
  output logic             in_range,
  output logic             write_fits
);

  localparam int SUM_W = ((OFF_W > LEN_W) ? OFF_W : LEN_W) + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      key    <= '0;
      offset <= '0;
    end else if (sel_load) begin
      key    <= sel_key;
      offset <= '0;
    end else if (jump) begin
      offset <= offset + OFF_W'(xfer_len);
    end else if (step) begin
      offset <= offset + OFF_W'(1);
    end
  end

  assign in_range   = SUM_W'(offset) < SUM_W'(item_len);
  assign write_fits = (SUM_W'(offset) + SUM_W'(xfer_len)) <= SUM_W'(item_len);

endmodule

// File: rtl/cfgdma_ctrl.sv
module cfgdma_ctrl
  import cfgdma_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter int LEN_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PTR_W-1:0]  ptr,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [3:0]        mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              sel_load,
  output logic [KEY_W-1:0]  sel_key,
  output logic              step,
  output logic              jump,
  output logic [LEN_W-1:0]  xfer_len,
  input  logic              in_range,
  input  logic              write_fits,
  input  logic [7:0]        item_rdata,
  input  logic              item_writable,
  output logic              item_wr,
  output logic [7:0]        item_wdata
);

  localparam int DESC_WORDS = 4;
  localparam int BEAT_W     = $clog2(DESC_WORDS);
  localparam logic [WORD_W-1:0] ERR_WORD = swap32(WORD_W'(1) << CTL_ERR);

  eng_state_t              state;
  eng_op_t                 op_q;
  logic [BEAT_W-1:0]       beat;
  logic [WORD_W-1:0]       desc_q [DESC_WORDS];
  logic [PTR_W-1:0]        desc_base;
  logic [PTR_W-1:0]        cur_addr;
  logic [LEN_W-1:0]        remain;
  logic                    fire;
  logic                    check_err;

  assign fire      = mem_req && mem_ready;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_WB) && fire;
  assign sel_load  = (state == S_DECODE) && desc_q[0][CTL_SEL];
  assign sel_key   = desc_q[0][WORD_W-1 -: KEY_W];
  assign xfer_len  = LEN_W'(desc_q[1]);
  assign jump      = (state == S_CHECK) && (op_q == OP_SKIP);
  assign step      = (state == S_MOVE) && fire;
  assign item_wr   = (state == S_MOVE) && (op_q == OP_WRITE) && fire;
  assign item_wdata = mem_rdata[{cur_addr[1:0], 3'b000} +: 8];
  assign check_err = (op_q == OP_WRITE) && (!item_writable || !write_fits);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= OP_NONE;
      beat      <= '0;
      desc_base <= '0;
      cur_addr  <= '0;
      remain    <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      for (int i = 0; i < DESC_WORDS; i++) desc_q[i] <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            desc_base <= ptr;
            mem_addr  <= ptr;
            mem_req   <= 1'b1;
            mem_we    <= 1'b0;
            mem_be    <= 4'hF;
            beat      <= '0;
            state     <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (fire) begin
            desc_q[beat] <= swap32(mem_rdata);
            if (beat == BEAT_W'(DESC_WORDS - 1)) begin
              mem_req <= 1'b0;
              state   <= S_DECODE;
            end else begin
              beat     <= beat + BEAT_W'(1);
              mem_addr <= mem_addr + PTR_W'(4);
            end
          end
        end
        S_DECODE: begin
          op_q     <= pick_op(desc_q[0]);
          cur_addr <= {desc_q[2], desc_q[3]};
          remain   <= LEN_W'(desc_q[1]);
          state    <= S_CHECK;
        end
        S_CHECK: begin
          if ((op_q == OP_READ || op_q == OP_WRITE) && !check_err && remain != '0) begin
            state <= S_MOVE;
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_be    <= 4'hF;
            mem_addr  <= desc_base;
            mem_wdata <= check_err ? ERR_WORD : '0;
            state     <= S_WB;
          end
        end
        S_MOVE: begin
          if (!mem_req) begin
            mem_req   <= 1'b1;
            mem_addr  <= cur_addr;
            mem_be    <= 4'b0001 << cur_addr[1:0];
            mem_we    <= (op_q == OP_READ);
            mem_wdata <= {4{in_range ? item_rdata : 8'h00}};
          end else if (fire) begin
            cur_addr <= cur_addr + PTR_W'(1);
            remain   <= remain - LEN_W'(1);
            if (remain == LEN_W'(1)) begin
              mem_we    <= 1'b1;
              mem_be    <= 4'hF;
              mem_addr  <= desc_base;
              mem_wdata <= '0;
              state     <= S_WB;
            end else begin
              mem_req <= 1'b0;
            end
          end
        end
        S_WB: begin
          if (fire) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            state   <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfgdma_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter int OFF_W = 32,
  parameter int LEN_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [3:0]        mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [KEY_W-1:0]  item_key,
  output logic [OFF_W-1:0]  item_offset,
  input  logic [7:0]        item_rdata,
  input  logic [LEN_W-1:0]  item_len,
  input  logic              item_writable,
  output logic              item_wr,
  output logic [7:0]        item_wdata
);

  logic [PTR_W-1:0] ptr_q;
  logic             start;
  logic             busy;
  logic             done;
  logic             sel_load;
  logic [KEY_W-1:0] sel_key;
  logic             step;
  logic             jump;
  logic [LEN_W-1:0] xfer_len;
  logic             in_range;
  logic             write_fits;

  cfgdma_ptr_reg u_ptr (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .done      (done),
    .ptr       (ptr_q),
    .start     (start)
  );

  cfgdma_cursor #(.KEY_W(KEY_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_cursor (
    .clk        (clk),
    .rst        (rst),
    .sel_load   (sel_load),
    .sel_key    (sel_key),
    .step       (step),
    .jump       (jump),
    .xfer_len   (xfer_len),
    .item_len   (item_len),
    .key        (item_key),
    .offset     (item_offset),
    .in_range   (in_range),
    .write_fits (write_fits)
  );

  cfgdma_ctrl #(.KEY_W(KEY_W), .LEN_W(LEN_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .ptr           (ptr_q),
    .busy          (busy),
    .done          (done),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_be        (mem_be),
    .mem_wdata     (mem_wdata),
    .mem_ready     (mem_ready),
    .mem_rdata     (mem_rdata),
    .sel_load      (sel_load),
    .sel_key       (sel_key),
    .step          (step),
    .jump          (jump),
    .xfer_len      (xfer_len),
    .in_range      (in_range),
    .write_fits    (write_fits),
    .item_rdata    (item_rdata),
    .item_writable (item_writable),
    .item_wr       (item_wr),
    .item_wdata    (item_wdata)
  );

endmodule

// File: rtl/cfgdma_checker.sv
module cfgdma_checker (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_ready,
  input logic        mem_we,
  input logic [63:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        item_wr,
  input logic        item_writable,
  input logic [31:0] item_offset,
  input logic [31:0] item_len,
  input logic        reg_wr,
  input logic        busy,
  input logic        done,
  input logic [63:0] ptr
);

  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                 && $stable(mem_be) && $stable(mem_wdata)));

  a_r6_lane_enable: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ($onehot(mem_be) || mem_be == 4'hF));

  a_r7_write_legal: assert property (@(posedge clk) disable iff (rst)
    item_wr |-> (item_writable && item_offset < item_len));

  a_r9_ptr_cleared: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (ptr == 64'd0));

  a_r3_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && reg_wr) |=> $stable(ptr));

endmodule

bind cfg_dma_engine cfgdma_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .mem_req       (mem_req),
  .mem_ready     (mem_ready),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_be        (mem_be),
  .mem_wdata     (mem_wdata),
  .item_wr       (item_wr),
  .item_writable (item_writable),
  .item_offset   (item_offset),
  .item_len      (item_len),
  .reg_wr        (reg_wr),
  .busy          (busy),
  .done          (done),
  .ptr           (ptr_q)
);

// File: tb/test_cfg_dma_engine.sv
module test_cfg_dma_engine;

  localparam int CLK_PERIOD = 10;
  localparam int N_ITEMS    = 4;
  localparam int ITEM_MAX   = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata;
  logic [15:0] item_key;
  logic [31:0] item_offset;
  logic [7:0]  item_rdata;
  logic [31:0] item_len;
  logic        item_writable;
  logic        item_wr;
  logic [7:0]  item_wdata;

  logic [7:0] mem [0:255];
  logic [7:0] item_mem [0:N_ITEMS-1][0:ITEM_MAX-1];
  logic [7:0] exp_item [0:N_ITEMS-1][0:ITEM_MAX-1];

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_dma_engine i_cfg_dma_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .item_key(item_key), .item_offset(item_offset),
    .item_rdata(item_rdata), .item_len(item_len), .item_writable(item_writable),
    .item_wr(item_wr), .item_wdata(item_wdata)
  );

  // memory and item store models
  logic [7:0] wa;
  assign wa = {mem_addr[7:2], 2'b00};
  assign mem_rdata = {mem[wa + 8'd3], mem[wa + 8'd2], mem[wa + 8'd1], mem[wa]};
  assign item_len = 32'd3 + 32'd4 * {30'd0, item_key[1:0]};
  assign item_writable = item_key[0];
  assign item_rdata = (item_offset < ITEM_MAX) ? item_mem[item_key[1:0]][item_offset[3:0]] : 8'h00;

  always @(posedge clk) begin
    if (mem_req && mem_ready && mem_we)
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) mem[wa + 8'(i)] <= mem_wdata[8*i +: 8];
    if (item_wr && item_offset < ITEM_MAX)
      item_mem[item_key[1:0]][item_offset[3:0]] <= item_wdata;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    mem_ready = (cyc % 3) != 1;
  end

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic int ilen(input int k);
    return 3 + 4 * k;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put_be32(input logic [7:0] a, input logic [31:0] v);
    mem[a]         <= v[31:24];
    mem[a + 8'd1]  <= v[23:16];
    mem[a + 8'd2]  <= v[15:8];
    mem[a + 8'd3]  <= v[7:0];
  endtask

  function automatic logic [31:0] get_be32(input logic [7:0] a);
    return {mem[a], mem[a + 8'd1], mem[a + 8'd2], mem[a + 8'd3]};
  endfunction

  task automatic fill(input logic [7:0] a, input int n, input logic [7:0] v);
    for (int i = 0; i < n; i++) mem[a + 8'(i)] <= v;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int tries = 0;
    s = 32'd1;
    while (s[0] && tries < 300) begin
      reg_read(2'd2, s);
      tries++;
    end
    chk("R9", "status idle after job", {63'd0, s[0]}, 64'd0);
  endtask

  task automatic dma(input logic [7:0] p, input logic [31:0] ctl, input logic [31:0] len, input logic [7:0] dst);
    put_be32(p, ctl);
    put_be32(p + 8'd4, len);
    put_be32(p + 8'd8, 32'd0);
    put_be32(p + 8'd12, {24'd0, dst});
    reg_write(2'd0, 32'd0);
    reg_write(2'd1, bswap({24'd0, p}));
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R9 watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] ctl;
    for (int k = 0; k < N_ITEMS; k++)
      for (int i = 0; i < ITEM_MAX; i++) begin
        item_mem[k][i] <= 8'((k * 16 + i) * 5 + 3);
        exp_item[k][i] = 8'((k * 16 + i) * 5 + 3);
      end
    for (int a = 0; a < 256; a++) mem[a] <= 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    reg_read(2'd0, rd); chk("R1", "ptr high after reset", rd, 0);
    reg_read(2'd1, rd); chk("R1", "ptr low after reset", rd, 0);
    reg_read(2'd2, rd); chk("R1", "status after reset", rd, 0);
    chk("R10", "no request after reset", mem_req, 0);
    chk("R5", "key after reset", item_key, 0);
    chk("R5", "offset after reset", item_offset, 0);

    // R2 byte order of high half
    reg_write(2'd0, 32'h44332211);
    reg_read(2'd0, rd); chk("R2", "ptr high readback", rd, 32'h44332211);
    reg_write(2'd0, 32'd0);

    // R4 R5 R6 R9 sweep over all items, reading past the end
    for (int k = 0; k < N_ITEMS; k++) begin
      fill(8'h80, 32, 8'hAA);
      dma(8'h00, {16'(k), 16'h000A}, 32'(ilen(k) + 2), 8'h81);
      chk("R9", "success word", get_be32(8'h00), 0);
      chk("R5", "key after select", item_key, 64'(k));
      chk("R6", "offset after read", item_offset, 64'(ilen(k) + 2));
      reg_read(2'd1, rd); chk("R1", "ptr cleared", rd, 0);
      for (int i = 0; i < ilen(k) + 2; i++)
        chk("R6", "read byte", mem[8'h81 + 8'(i)], (i < ilen(k)) ? exp_item[k][i] : 8'h00);
      chk("R6", "no overrun", mem[8'h81 + 8'(ilen(k) + 2)], 8'hAA);
    end

    // R6 continuation without select
    dma(8'h00, {16'd3, 16'h000A}, 32'd4, 8'h80);
    dma(8'h00, 32'h0000_0002, 32'd4, 8'h90);
    for (int i = 0; i < 4; i++) chk("R6", "continued byte", mem[8'h90 + 8'(i)], exp_item[3][4 + i]);

    // R8 skip moves no data
    fill(8'h80, 32, 8'hAA);
    dma(8'h00, {16'd3, 16'h000C}, 32'd5, 8'h80);
    chk("R8", "offset after skip", item_offset, 5);
    chk("R8", "skip moved no data", mem[8'h80], 8'hAA);
    dma(8'h00, 32'h0000_0002, 32'd3, 8'h80);
    for (int i = 0; i < 3; i++) chk("R8", "read after skip", mem[8'h80 + 8'(i)], exp_item[3][5 + i]);

    // R7 write success on writable item 1
    for (int i = 0; i < 8; i++) mem[8'hA0 + 8'(i)] <= 8'hC0 + 8'(i);
    dma(8'h00, {16'd1, 16'h0018}, 32'd4, 8'hA0);
    chk("R9", "write success word", get_be32(8'h00), 0);
    chk("R7", "offset after write", item_offset, 4);
    for (int i = 0; i < 4; i++) exp_item[1][i] = 8'hC0 + 8'(i);
    // R7 out-of-range write: offset 5, length 4, item length 7
    dma(8'h00, {16'd1, 16'h000C}, 32'd5, 8'h80);
    dma(8'h00, 32'h0000_0010, 32'd4, 8'hA0);
    chk("R9", "error word", get_be32(8'h00), 1);
    chk("R7", "offset unchanged on error", item_offset, 5);
    // R7 write exactly to the end
    dma(8'h00, 32'h0000_0010, 32'd2, 8'hA4);
    chk("R7", "end write success", get_be32(8'h00), 0);
    exp_item[1][5] = 8'hC4; exp_item[1][6] = 8'hC5;
    dma(8'h00, {16'd1, 16'h000A}, 32'd7, 8'h80);
    for (int i = 0; i < 7; i++) chk("R7", "item after writes", mem[8'h80 + 8'(i)], exp_item[1][i]);

    // R7 read-only item rejects write
    dma(8'h00, {16'd2, 16'h0018}, 32'd1, 8'hA0);
    chk("R7", "read-only error word", get_be32(8'h00), 1);
    chk("R7", "read-only item unchanged", item_mem[2][0], exp_item[2][0]);

    // R6 read outranks write
    dma(8'h00, {16'd1, 16'h001A}, 32'd3, 8'h90);
    for (int i = 0; i < 3; i++) chk("R6", "read wins over write", mem[8'h90 + 8'(i)], exp_item[1][i]);
    chk("R6", "item untouched by priority", item_mem[1][0], exp_item[1][0]);

    // R7 write outranks skip
    dma(8'h00, {16'd3, 16'h001C}, 32'd2, 8'hA6);
    exp_item[3][0] = 8'hC6; exp_item[3][1] = 8'hC7;
    chk("R7", "write wins over skip b0", item_mem[3][0], exp_item[3][0]);
    chk("R7", "write wins over skip b1", item_mem[3][1], exp_item[3][1]);

    // R5 select alone resets offset
    dma(8'h00, {16'd3, 16'h0008}, 32'd9, 8'h80);
    chk("R5", "select only offset", item_offset, 0);
    chk("R9", "select only success", get_be32(8'h00), 0);

    // R6 zero length read
    fill(8'h80, 4, 8'h55);
    dma(8'h00, {16'd0, 16'h000A}, 32'd0, 8'h80);
    chk("R6", "zero length untouched", mem[8'h80], 8'h55);
    chk("R6", "zero length offset", item_offset, 0);

    // R3 trigger while busy is ignored, R1 busy visible
    put_be32(8'h40, 32'h0000_0004);
    put_be32(8'h44, 32'd1);
    put_be32(8'h48, 32'd0);
    put_be32(8'h4C, 32'd0);
    put_be32(8'h00, {16'd3, 16'h000A});
    put_be32(8'h04, 32'd12);
    put_be32(8'h08, 32'd0);
    put_be32(8'h0C, 32'h0000_0080);
    reg_write(2'd0, 32'd0);
    reg_write(2'd1, bswap(32'h0000_0000));
    reg_write(2'd1, bswap(32'h0000_0040));
    reg_read(2'd2, rd); chk("R1", "busy while running", rd, 1);
    wait_idle();
    chk("R3", "first job done", get_be32(8'h00), 0);
    chk("R3", "second trigger ignored", get_be32(8'h40), 32'h0000_0004);
    chk("R3", "offset from first job only", item_offset, 12);
    reg_read(2'd1, rd); chk("R1", "ptr cleared after busy test", rd, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule